// File: doc/BRIEF.md
# PCIe Endpoint Configuration-Ready Gate

This block sits on the endpoint side of a PCI Express controller, between the local processor and inbound Type 0 configuration requests from the host. Local software uses a plain register port to load the subsystem identifiers that the host will later read from the configuration header. When that is done, software sets a ready flag. Until the flag is set, every inbound configuration request is answered with Configuration Request Retry Status. The host therefore cannot enumerate the function before its header holds the final values.

Requests arrive on a valid/ready channel. Each accepted request gives exactly one completion on a second valid/ready channel, carrying a 3-bit status and a 32-bit data word. Apart from the subsystem dword, the configuration space is a stub that returns zero. A power-on strap gives the reset value of the ready flag, so a part that is strapped to boot ready can answer the host without any help from software.

Top module: `cfg_ready_gate`

## Requirements
- R1: After reset, no completion is valid, request ready is high, the subsystem register reads zero, and the ready flag equals the strap input `strap_ready_i`.
- R2: In endpoint mode (`ep_mode_i`=1), a local write to byte offset 0x478 stores the subsystem ID from bits 31:16 and the subsystem vendor ID from bits 15:0, and a local read of 0x478 returns them in the same positions.
- R3: In root-complex mode (`ep_mode_i`=0), a local read of 0x478 returns zero and a local write to 0x478 leaves the stored value unchanged.
- R4: A local read of offset 0x4B0 returns the ready flag in bit 0 with all other bits zero. A write with bit 0 set sets the flag. A write with bit 0 clear does not clear it.
- R5: While the ready flag is 0, every configuration request, read or write, completes with status 3'b010 (retry) and data zero.
- R6: While the ready flag is 1, every configuration request completes with status 3'b000 (successful).
- R7: With the flag set, a configuration read of register number 11 (header byte 0x2C) returns the subsystem ID in bits 31:16 and the subsystem vendor ID in bits 15:0. Reads of any other register, and all writes, carry data zero.
- R8: Configuration writes to register number 11 have no effect on the value that later reads return.
- R9: A request accepted on a clock edge produces exactly one completion, valid from that edge until the consumer takes it. Request ready is low while a completion is held and `cpl_ready_i` is low, and the completion holds stable during that time.
- R10: A local read of any offset other than 0x478 and 0x4B0 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_ready_i | input | 1 | Power-on strap: reset value of the ready flag |
| ep_mode_i | input | 1 | 1 = endpoint mode, 0 = root-complex mode |
| lb_wen_i | input | 1 | Local write strobe |
| lb_addr_i | input | 12 | Local byte offset |
| lb_wdata_i | input | 32 | Local write data |
| lb_rdata_o | output | 32 | Local read data, combinational from the offset |
| req_valid_i | input | 1 | Configuration request valid |
| req_ready_o | output | 1 | Configuration request ready |
| req_write_i | input | 1 | 1 = configuration write, 0 = read |
| req_regnum_i | input | 10 | Dword register number within the Type 0 header space |
| req_wdata_i | input | 32 | Configuration write data |
| cpl_valid_o | output | 1 | Completion valid |
| cpl_ready_i | input | 1 | Completion consumer ready |
| cpl_status_o | output | 3 | Completion status: 000 successful, 010 retry |
| cpl_data_o | output | 32 | Completion data |

## Verification
The bench attacks the ready flag's stickiness. A design that decoded the flag as ordinary read/write storage would fall back to retry after a write of zero, and every host request after that would report the wrong status. It also targets root-complex mode: a block that gated only the read path would take the write, and the stored identifiers would change once endpoint mode returned. It checks that host writes to the subsystem dword cannot corrupt it, and that a completion stalled by the consumer neither drops, repeats, nor changes its data. Finally, a reset with the strap high shows that the flag is not reset to a fixed zero.

// File: rtl/cfg_gate_pkg.sv
`timescale 1ns/1ps
package cfg_gate_pkg;
    localparam int LB_AW  = 12;
    localparam int DW     = 32;
    localparam int REGN_W = 10;
    localparam int HALF_W = DW / 2;

    localparam logic [LB_AW-1:0]  OFS_SUBSYS = 12'h478;
    localparam logic [LB_AW-1:0]  OFS_READY  = 12'h4B0;
    localparam logic [REGN_W-1:0] HDR_SUBSYS_REG = 10'd11;

    typedef enum logic [2:0] {
        CPL_SC  = 3'b000,
        CPL_CRS = 3'b010
    } cpl_status_e;

    typedef struct packed {
        logic [HALF_W-1:0] ss_id;
        logic [HALF_W-1:0] ssv_id;
    } subsys_t;

    typedef struct packed {
        logic              wr;
        logic [REGN_W-1:0] regnum;
        logic [DW-1:0]     wdata;
    } cfg_req_t;

    typedef struct packed {
        cpl_status_e   status;
        logic [DW-1:0] data;
    } cpl_t;

    // Decide the completion for one request from the gate state and header contents.
    function automatic cpl_t resolve_cpl(logic gate_open, cfg_req_t req, subsys_t ss);
        cpl_t c;
        c.status = CPL_CRS;
        c.data   = '0;
        if (gate_open) begin
            c.status = CPL_SC;
            if (!req.wr && req.regnum == HDR_SUBSYS_REG)
                c.data = ss;
        end
        return c;
    endfunction
endpackage

// File: rtl/cfg_gate_lbregs.sv
`timescale 1ns/1ps
module cfg_gate_lbregs
    import cfg_gate_pkg::*;
#(
    parameter int AW = LB_AW,
    parameter int W  = DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strap_ready,
    input  logic          ep_mode,
    input  logic          wen,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output subsys_t       ss,
    output logic          gate_open
);
    subsys_t ss_q;
    logic    open_q;

    wire hit_subsys = (addr == OFS_SUBSYS);
    wire hit_ready  = (addr == OFS_READY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ss_q   <= '0;
            open_q <= strap_ready;
        end else if (wen) begin
            if (hit_subsys && ep_mode)
                ss_q <= subsys_t'(wdata);
            if (hit_ready && wdata[0])
                open_q <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_subsys && ep_mode)
            rdata = ss_q;
        else if (hit_ready)
            rdata[0] = open_q;
    end

    assign ss        = ss_q;
    assign gate_open = open_q;
endmodule

// File: rtl/cfg_gate_cpl.sv
`timescale 1ns/1ps
module cfg_gate_cpl
    import cfg_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  cfg_req_t req,
    output logic     req_ready,
    input  logic     gate_open,
    input  subsys_t  ss,
    output logic     cpl_valid,
    input  logic     cpl_ready,
    output cpl_t     cpl
);
    logic cpl_valid_q;
    cpl_t cpl_q;

    wire fire = req_valid && req_ready;

    assign req_ready = !cpl_valid_q || cpl_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpl_valid_q <= 1'b0;
            cpl_q       <= '{status: CPL_SC, data: '0};
        end else if (fire) begin
            cpl_valid_q <= 1'b1;
            cpl_q       <= resolve_cpl(gate_open, req, ss);
        end else if (cpl_ready) begin
            cpl_valid_q <= 1'b0;
        end
    end

    assign cpl_valid = cpl_valid_q;
    assign cpl       = cpl_q;
endmodule

// File: rtl/cfg_ready_gate.sv
`timescale 1ns/1ps
module cfg_ready_gate
    import cfg_gate_pkg::*;
#(
    parameter int AW   = LB_AW,
    parameter int W    = DW,
    parameter int RN_W = REGN_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            strap_ready_i,
    input  logic            ep_mode_i,
    input  logic            lb_wen_i,
    input  logic [AW-1:0]   lb_addr_i,
    input  logic [W-1:0]    lb_wdata_i,
    output logic [W-1:0]    lb_rdata_o,
    input  logic            req_valid_i,
    output logic            req_ready_o,
    input  logic            req_write_i,
    input  logic [RN_W-1:0] req_regnum_i,
    input  logic [W-1:0]    req_wdata_i,
    output logic            cpl_valid_o,
    input  logic            cpl_ready_i,
    output logic [2:0]      cpl_status_o,
    output logic [W-1:0]    cpl_data_o
);
    subsys_t  ss;
    logic     gate_open;
    cfg_req_t req;
    cpl_t     cpl;

    assign req = '{wr: req_write_i, regnum: req_regnum_i, wdata: req_wdata_i};

    cfg_gate_lbregs #(.AW(AW), .W(W)) regs_i (
        .clk         (clk),
        .rst         (rst),
        .strap_ready (strap_ready_i),
        .ep_mode     (ep_mode_i),
        .wen         (lb_wen_i),
        .addr        (lb_addr_i),
        .wdata       (lb_wdata_i),
        .rdata       (lb_rdata_o),
        .ss          (ss),
        .gate_open   (gate_open)
    );

    cfg_gate_cpl cpl_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid_i),
        .req       (req),
        .req_ready (req_ready_o),
        .gate_open (gate_open),
        .ss        (ss),
        .cpl_valid (cpl_valid_o),
        .cpl_ready (cpl_ready_i),
        .cpl       (cpl)
    );

    assign cpl_status_o = cpl.status;
    assign cpl_data_o   = cpl.data;
endmodule

// File: rtl/cfg_ready_gate_chk.sv
`timescale 1ns/1ps
module cfg_ready_gate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid_i,
    input logic        req_ready_o,
    input logic        cpl_valid_o,
    input logic        cpl_ready_i,
    input logic [2:0]  cpl_status_o,
    input logic [31:0] cpl_data_o,
    input logic        gate_open
);
    wire fire = req_valid_i && req_ready_o;

    // R9: an accepted request is followed by a valid completion
    a_r9_cpl_follows: assert property (@(posedge clk) disable iff (rst)
        fire |=> cpl_valid_o);

    // R9: back-pressure on the completion stops intake
    a_r9_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid_o && !cpl_ready_i) |-> !req_ready_o);

    // R9: a stalled completion holds its content
    a_r9_stall_stable: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid_o && !cpl_ready_i) |=> (cpl_valid_o && $stable(cpl_status_o) && $stable(cpl_data_o)));

    // R5: gate closed at acceptance gives retry with zero data
    a_r5_closed_retry: assert property (@(posedge clk) disable iff (rst)
        (fire && !gate_open) |=> (cpl_status_o == 3'b010 && cpl_data_o == 32'd0));

    // R6: gate open at acceptance gives successful status
    a_r6_open_success: assert property (@(posedge clk) disable iff (rst)
        (fire && gate_open) |=> (cpl_status_o == 3'b000));

    // R4: the ready flag never falls outside reset
    a_r4_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        !$fell(gate_open));
endmodule

bind cfg_ready_gate cfg_ready_gate_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .cpl_valid_o  (cpl_valid_o),
    .cpl_ready_i  (cpl_ready_i),
    .cpl_status_o (cpl_status_o),
    .cpl_data_o   (cpl_data_o),
    .gate_open    (gate_open)
);

// File: tb/cfg_ready_gate_tb.sv
`timescale 1ns/1ps
module cfg_ready_gate_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_ready_i = 1'b0;
    logic        ep_mode_i = 1'b1;
    logic        lb_wen_i = 1'b0;
    logic [11:0] lb_addr_i = '0;
    logic [31:0] lb_wdata_i = '0;
    logic [31:0] lb_rdata_o;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic        req_write_i = 1'b0;
    logic [9:0]  req_regnum_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic        cpl_valid_o;
    logic        cpl_ready_i = 1'b1;
    logic [2:0]  cpl_status_o;
    logic [31:0] cpl_data_o;

    cfg_ready_gate dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_ss = '0;
    logic        m_open = 1'b0;

    function automatic logic [2:0] exp_status(logic open);
        return open ? 3'b000 : 3'b010;
    endfunction

    function automatic logic [31:0] exp_data(logic open, logic wr, logic [9:0] rn, logic [31:0] ss);
        return (open && !wr && rn == 10'd11) ? ss : 32'd0;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(logic strap);
        @(negedge clk);
        strap_ready_i = strap;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_ss = '0;
        m_open = strap;
    endtask

    task automatic lb_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        lb_addr_i = a; lb_wdata_i = d; lb_wen_i = 1'b1;
        if (a == 12'h478 && ep_mode_i) m_ss = d;
        if (a == 12'h4B0 && d[0]) m_open = 1'b1;
        @(negedge clk);
        lb_wen_i = 1'b0;
    endtask

    task automatic lb_read(string req, logic [11:0] a, logic [31:0] exp);
        @(negedge clk);
        lb_addr_i = a;
        #1;
        chk(req, "local read", lb_rdata_o, exp);
    endtask

    task automatic cfg_req(string req, logic wr, logic [9:0] rn, logic [31:0] d);
        logic [31:0] ed;
        logic [2:0]  es;
        @(negedge clk);
        ed = exp_data(m_open, wr, rn, m_ss);
        es = exp_status(m_open);
        req_valid_i = 1'b1; req_write_i = wr; req_regnum_i = rn; req_wdata_i = d;
        chk("R9", "req_ready before issue", {31'd0, req_ready_o}, 32'd1);
        @(negedge clk);
        req_valid_i = 1'b0;
        chk("R9", "cpl_valid after accept", {31'd0, cpl_valid_o}, 32'd1);
        chk(req, "cpl status", {29'd0, cpl_status_o}, {29'd0, es});
        chk(req, "cpl data", cpl_data_o, ed);
        @(negedge clk);
        chk("R9", "single completion", {31'd0, cpl_valid_o}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b0);
        // R1 reset state
        chk("R1", "cpl_valid", {31'd0, cpl_valid_o}, 32'd0);
        chk("R1", "req_ready", {31'd0, req_ready_o}, 32'd1);
        lb_read("R1", 12'h478, 32'd0);
        lb_read("R1", 12'h4B0, 32'd0);

        // R5 closed gate: reads and writes retry
        cfg_req("R5", 1'b0, 10'd11, 32'd0);
        cfg_req("R5", 1'b1, 10'd11, 32'hDEAD_0001);
        lb_write(12'h478, 32'hBEEF_1957);
        lb_read("R2", 12'h478, 32'hBEEF_1957);
        cfg_req("R5", 1'b0, 10'd11, 32'd0);

        // R3 root-complex mode
        ep_mode_i = 1'b0;
        lb_read("R3", 12'h478, 32'd0);
        lb_write(12'h478, 32'h1111_2222);
        ep_mode_i = 1'b1;
        lb_read("R3", 12'h478, 32'hBEEF_1957);

        // R10 unmapped offsets
        lb_read("R10", 12'h400, 32'd0);
        lb_read("R10", 12'h47C, 32'd0);

        // R4 ready flag
        lb_write(12'h4B0, 32'hFFFF_FFFE);
        lb_read("R4", 12'h4B0, 32'd0);
        lb_write(12'h4B0, 32'hFFFF_FFFF);
        lb_read("R4", 12'h4B0, 32'd1);
        lb_write(12'h4B0, 32'd0);
        lb_read("R4", 12'h4B0, 32'd1);

        // R6/R7 open gate
        cfg_req("R7", 1'b0, 10'd11, 32'd0);
        cfg_req("R7", 1'b0, 10'd0, 32'd0);
        cfg_req("R6", 1'b1, 10'd3, 32'h1234_5678);
        // R8 host write to subsystem dword ignored
        cfg_req("R8", 1'b1, 10'd11, 32'h0000_0000);
        cfg_req("R8", 1'b0, 10'd11, 32'd0);

        // R9 stall
        @(negedge clk);
        cpl_ready_i = 1'b0;
        req_valid_i = 1'b1; req_write_i = 1'b0; req_regnum_i = 10'd11;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk("R9", "stall valid", {31'd0, cpl_valid_o}, 32'd1);
        chk("R9", "stall req_ready low", {31'd0, req_ready_o}, 32'd0);
        req_valid_i = 1'b1; req_regnum_i = 10'd5;
        @(negedge clk);
        chk("R9", "stall held data", cpl_data_o, m_ss);
        chk("R9", "stall held valid", {31'd0, cpl_valid_o}, 32'd1);
        req_valid_i = 1'b0;
        cpl_ready_i = 1'b1;
        @(negedge clk);
        chk("R9", "drained", {31'd0, cpl_valid_o}, 32'd0);

        // random mix
        do_reset(1'b0);
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 9);
            if (op == 0) begin
                ep_mode_i = 1'($urandom_range(0, 1));
                lb_write(12'h478, $urandom());
                ep_mode_i = 1'b1;
            end else if (op == 1 && $urandom_range(0, 5) == 0) begin
                lb_write(12'h4B0, $urandom());
            end else if (op == 2) begin
                lb_read("R4", 12'h4B0, {31'd0, m_open});
            end else begin
                logic [9:0] rn = ($urandom_range(0, 1) == 1) ? 10'd11 : 10'($urandom_range(0, 63));
                logic wr = 1'($urandom_range(0, 1));
                cfg_req(m_open ? "R7" : "R5", wr, rn, $urandom());
            end
        end
        lb_read("R2", 12'h478, m_ss);

        // R1 strap
        do_reset(1'b1);
        lb_read("R1", 12'h4B0, 32'd1);
        lb_read("R1", 12'h478, 32'd0);
        cfg_req("R6", 1'b0, 10'd11, 32'd0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule